// File: doc/BRIEF.md
# Interrupt Pend and Active Tracker

This block sits between a small group of interrupt lines and a processor. For every line it keeps three bits: whether the line is allowed to interrupt (enable), whether a request is waiting (pending), and whether the processor is currently running its handler (active). It presents to the processor one request at a time. That request is the lowest-numbered line that is enabled and pending and not already active.

No line carries a mode bit. A single-cycle pulse and a held level are both handled by the same two rules. A rising input always marks the line pending, even while the line is active. When the processor returns from a handler, the input is sampled again, so a level that is still high makes the line pending again.

Software reaches the state through a small register bus. There are write-one-to-set and write-one-to-clear registers for enable and for pending, a read-only view of the active bits, and a trigger register that takes a line number. The processor side uses two handshakes, each carrying a line number. The acknowledge handshake says the processor has vectored to that line. The return handshake says the processor has left that line's handler.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A rising edge on an input line (high this cycle, low the previous cycle) sets that line's pending bit at the next clock edge. A level held high does not set the bit again by itself.
- R2: An acknowledge for line n sets active[n] and clears pending[n] at the next clock edge.
- R3: A new rising edge on a line whose active bit is set makes the line pending again. The active bit stays set.
- R4: A return for line n clears active[n]. If input n is high in that same cycle, pending[n] is set. If input n is low, pending[n] is left as it was.
- R5: Enable bits are changed only through their registers and are independent of pending bits. Writing 1s to address 0 sets enable bits, and writing 1s to address 1 clears them. A disabled line still becomes pending and stays pending. It is offered to the processor only once it is enabled.
- R6: Writing 1s to address 2 sets the matching pending bits, with the same effect as a hardware rising edge.
- R7: Writing line number k to address 5 (number in the low data bits) sets pending[k].
- R8: req_valid/req_id give the lowest-numbered line that is enabled, pending and not active, in the cycle after that state holds. When there is no such line, req_valid is 0.
- R9: A 0 data bit written to address 0, 1, 2 or 3 leaves the matching bit unchanged.
- R10: Writing 1s to address 3 clears the matching pending bits. If a clear-pending write and a rising edge on the same line happen in the same cycle, the line stays pending.
- R11: A read strobe returns, in the following cycle on bus_rdata, the enable bits for address 0, the pending bits for address 2, and the active bits for address 4. Any other address reads 0.
- R12: Synchronous reset clears all enable, pending and active bits, the request output and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Interrupt inputs, synchronous to clk |
| ack_valid | input | 1 | Processor has vectored to a line |
| ack_id | input | ID_W | Line being vectored to |
| ret_valid | input | 1 | Processor has returned from a handler |
| ret_id | input | ID_W | Line whose handler returned |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, registered |
| req_valid | output | 1 | A line is offered to the processor |
| req_id | output | ID_W | Number of the offered line |

## Verification
The hardest case to reach is a line that becomes pending again while its handler is running. This happens in two ways: through a new pulse on the line, or through a level that is still high at the moment of return. In both cases the line must be offered again only after the return, and the order of events matters. The stimulus acknowledges a line, holds or re-pulses its input while the line is active, and then issues the return at a chosen input level. The pending and active bits are read back both before and after the return. A separate step lines up a clear-pending write with a rising edge in the same cycle.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN_SET = 3'd0,
    RA_EN_CLR = 3'd1,
    RA_PD_SET = 3'd2,
    RA_PD_CLR = 3'd3,
    RA_ACTIVE = 3'd4,
    RA_TRIG   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] rise
);
  logic [NUM_LINES-1:0] lines_q;

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= lines;
  end

  assign rise = lines & ~lines_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic level,
  input  logic ack_hit,
  input  logic ret_hit,
  input  logic en_set,
  input  logic en_clr,
  input  logic pd_set,
  input  logic pd_clr,
  input  logic trig_hit,
  output logic en,
  output logic pd,
  output logic act
);
  logic set_any;
  logic clr_any;

  // Any source that raises a request wins over any source that drops it.
  assign set_any = rise | (ret_hit & level) | pd_set | trig_hit;
  assign clr_any = ack_hit | pd_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      pd  <= 1'b0;
      act <= 1'b0;
    end else begin
      if (en_set)      en <= 1'b1;
      else if (en_clr) en <= 1'b0;

      if (set_any)      pd <= 1'b1;
      else if (clr_any) pd <= 1'b0;

      if (ack_hit)      act <= 1'b1;
      else if (ret_hit) act <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_pc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ID_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  input  logic [NUM_LINES-1:0] en_vec,
  input  logic [NUM_LINES-1:0] pd_vec,
  input  logic [NUM_LINES-1:0] act_vec,
  output logic [NUM_LINES-1:0] en_set,
  output logic [NUM_LINES-1:0] en_clr,
  output logic [NUM_LINES-1:0] pd_set,
  output logic [NUM_LINES-1:0] pd_clr,
  output logic [NUM_LINES-1:0] trig_hit,
  output logic [NUM_LINES-1:0] bus_rdata
);
  localparam logic [ID_W:0] LINES_W = (ID_W+1)'(NUM_LINES);

  logic [ID_W-1:0] trig_id;
  logic            trig_ok;

  assign trig_id = bus_wdata[ID_W-1:0];
  assign trig_ok = bus_wr && (bus_addr == RA_TRIG) && ({1'b0, trig_id} < LINES_W);

  assign en_set = (bus_wr && bus_addr == RA_EN_SET) ? bus_wdata : '0;
  assign en_clr = (bus_wr && bus_addr == RA_EN_CLR) ? bus_wdata : '0;
  assign pd_set = (bus_wr && bus_addr == RA_PD_SET) ? bus_wdata : '0;
  assign pd_clr = (bus_wr && bus_addr == RA_PD_CLR) ? bus_wdata : '0;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_trig
      assign trig_hit[g] = trig_ok && (trig_id == ID_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_EN_SET: bus_rdata <= en_vec;
        RA_PD_SET: bus_rdata <= pd_vec;
        RA_ACTIVE: bus_rdata <= act_vec;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  parameter int ID_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] cand,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id
);
  logic            found;
  logic [ID_W-1:0] idx;

  // Scan from the top down so the lowest index is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_id    <= '0;
    end else begin
      req_valid <= found;
      req_id    <= idx;
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 ret_valid,
  input  logic [ID_W-1:0]      ret_id,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [2:0]           bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id
);
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] en_vec, pd_vec, act_vec;
  logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr, trig_hit;
  logic [NUM_LINES-1:0] ack_hit, ret_hit;
  logic [NUM_LINES-1:0] cand;

  irq_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lines (irq_in),
    .rise  (rise)
  );

  irq_reg_if #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_vec    (en_vec),
    .pd_vec    (pd_vec),
    .act_vec   (act_vec),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .pd_set    (pd_set),
    .pd_clr    (pd_clr),
    .trig_hit  (trig_hit),
    .bus_rdata (bus_rdata)
  );

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign ack_hit[g] = ack_valid && (ack_id == ID_W'(g));
      assign ret_hit[g] = ret_valid && (ret_id == ID_W'(g));

      irq_line_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise[g]),
        .level    (irq_in[g]),
        .ack_hit  (ack_hit[g]),
        .ret_hit  (ret_hit[g]),
        .en_set   (en_set[g]),
        .en_clr   (en_clr[g]),
        .pd_set   (pd_set[g]),
        .pd_clr   (pd_clr[g]),
        .trig_hit (trig_hit[g]),
        .en       (en_vec[g]),
        .pd       (pd_vec[g]),
        .act      (act_vec[g])
      );
    end
  endgenerate

  assign cand = en_vec & pd_vec & ~act_vec;

  irq_prio_pick #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .cand      (cand),
    .req_valid (req_valid),
    .req_id    (req_id)
  );
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int ID_W      = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 ack_valid,
  input logic [ID_W-1:0]      ack_id,
  input logic                 ret_valid,
  input logic [ID_W-1:0]      ret_id,
  input logic                 bus_wr,
  input logic [2:0]           bus_addr,
  input logic [NUM_LINES-1:0] bus_wdata,
  input logic                 req_valid,
  input logic [ID_W-1:0]      req_id,
  input logic [NUM_LINES-1:0] en_vec,
  input logic [NUM_LINES-1:0] pd_vec,
  input logic [NUM_LINES-1:0] act_vec
);
  logic [NUM_LINES-1:0] cand_q;

  always_ff @(posedge clk) begin
    if (rst) cand_q <= '0;
    else     cand_q <= en_vec & pd_vec & ~act_vec;
  end

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_rise
      a_r1_rise_pends: assert property (@(posedge clk) disable iff (rst)
        (irq_in[g] && !$past(irq_in[g])) |=> pd_vec[g]);
    end
  endgenerate

  a_r2_ack_activates: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !(ret_valid && ret_id == ack_id)) |=> act_vec[$past(ack_id)]);

  a_r4_ret_deactivates: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !(ack_valid && ack_id == ret_id)) |=> !act_vec[$past(ret_id)]);

  a_r4_ret_resamples: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && irq_in[ret_id]) |=> pd_vec[$past(ret_id)]);

  a_r7_trigger_pends: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd5) |=> pd_vec[$past(bus_wdata[ID_W-1:0])]);

  a_r8_req_is_candidate: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> cand_q[req_id]);

  a_r8_req_lowest: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((cand_q & ((NUM_LINES'(1) << req_id) - NUM_LINES'(1))) == '0));

  a_r8_idle_when_none: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (cand_q == '0));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .ack_valid (ack_valid),
  .ack_id    (ack_id),
  .ret_valid (ret_valid),
  .ret_id    (ret_id),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req_valid (req_valid),
  .req_id    (req_id),
  .en_vec    (en_vec),
  .pd_vec    (pd_vec),
  .act_vec   (act_vec)
);

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  localparam int N    = 8;
  localparam int IW   = 3;
  localparam logic [2:0] A_ENS = 3'd0, A_ENC = 3'd1, A_PDS = 3'd2,
                         A_PDC = 3'd3, A_ACT = 3'd4, A_TRG = 3'd5, A_REQ = 3'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          ack_valid = 1'b0, ret_valid = 1'b0;
  logic [IW-1:0] ack_id = '0, ret_id = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          req_valid;
  logic [IW-1:0] req_id;

  always #2 clk = ~clk;

  irq_pend_ctrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .ret_valid(ret_valid), .ret_id(ret_id),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_id(req_id)
  );

  typedef struct {
    logic [2:0]   addr;
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic  rd_seen  = 1'b0;

  // Monitor: one sample per observation strobe, compared with the queued item.
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = sb_q.pop_front();
      if (it.addr == A_REQ) act = req_valid ? N'({1'b1, req_id}) : '0;
      else                  act = bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic ack(input int id);
    ack_valid = 1'b1; ack_id = IW'(id);
    cyc();
    ack_valid = 1'b0;
  endtask

  task automatic ret(input int id);
    ret_valid = 1'b1; ret_id = IW'(id);
    cyc();
    ret_valid = 1'b0;
  endtask

  task automatic expect_at(input logic [2:0] a, input logic [N-1:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0;
  endtask

  function automatic logic [N-1:0] rq(input int id);
    return N'({1'b1, IW'(id)});
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst = 1'b0;
    // R12 reset state
    expect_at(A_ENS, '0, "R12 enable after reset");
    expect_at(A_PDS, '0, "R12 pending after reset");
    expect_at(A_ACT, '0, "R12 active after reset");
    expect_at(A_REQ, '0, "R12 request after reset");

    // R1 level on line 3, R5 disabled but pending
    irq_in[3] = 1'b1; cyc(); cyc();
    expect_at(A_PDS, 8'h08, "R1 rise sets pending");
    expect_at(A_REQ, '0, "R5 disabled line not offered");
    wr(A_ENS, 8'h08);
    expect_at(A_ENS, 8'h08, "R5 enable set");
    expect_at(A_REQ, rq(3), "R5 offered once enabled");
    ack(3);
    expect_at(A_PDS, 8'h00, "R2 ack clears pending");
    expect_at(A_ACT, 8'h08, "R2 ack sets active");
    expect_at(A_PDS, 8'h00, "R1 held level does not repend");
    // R4 return with level still high
    ret(3);
    expect_at(A_ACT, 8'h00, "R4 return clears active");
    expect_at(A_PDS, 8'h08, "R4 resample still high");
    ack(3);
    irq_in[3] = 1'b0; cyc();
    ret(3);
    expect_at(A_PDS, 8'h00, "R4 no resample when low");

    // R3 pulse while active on line 5
    wr(A_ENS, 8'h20);
    irq_in[5] = 1'b1; cyc(); irq_in[5] = 1'b0;
    ack(5);
    irq_in[5] = 1'b1; cyc(); irq_in[5] = 1'b0;
    expect_at(A_PDS, 8'h20, "R3 repend while active");
    expect_at(A_ACT, 8'h20, "R3 active kept");
    expect_at(A_REQ, '0, "R8 active line excluded");
    ret(5);
    expect_at(A_REQ, rq(5), "R3 serviced again after return");
    ack(5); ret(5);

    // R6 set-pending, R8 priority, R9 zero writes, R5 clear-enable
    wr(A_ENS, 8'hFF);
    wr(A_PDS, 8'h84);
    expect_at(A_PDS, 8'h84, "R6 set-pending");
    expect_at(A_REQ, rq(2), "R8 lowest line chosen");
    wr(A_PDS, 8'h00); wr(A_PDC, 8'h00); wr(A_ENC, 8'h00); wr(A_ENS, 8'h00);
    expect_at(A_PDS, 8'h84, "R9 zero writes keep pending");
    expect_at(A_ENS, 8'hFF, "R9 zero writes keep enable");
    wr(A_ENC, 8'h04);
    expect_at(A_ENS, 8'hFB, "R5 clear-enable");
    expect_at(A_REQ, rq(7), "R5 disabled lower line skipped");
    expect_at(A_PDS, 8'h84, "R5 pending independent of enable");
    wr(A_PDC, 8'h84);
    expect_at(A_PDS, 8'h00, "R10 clear-pending");

    // R7 trigger
    wr(A_TRG, 8'd6);
    expect_at(A_PDS, 8'h40, "R7 trigger sets pending");
    expect_at(A_REQ, rq(6), "R7 triggered line offered");
    wr(A_PDC, 8'h40);

    // R10 clear coinciding with rise
    irq_in[1] = 1'b1;
    wr(A_PDC, 8'h02);
    expect_at(A_PDS, 8'h02, "R10 rise beats clear");
    irq_in[1] = 1'b0;
    wr(A_PDC, 8'h02);
    expect_at(A_PDS, 8'h00, "R10 clear after rise");
    expect_at(A_TRG, 8'h00, "R11 other address reads zero");
    cyc(); cyc();

    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule